// File: doc/BRIEF.md
# Three-Register Stack Processor Core

This block is a tiny 64-bit stack machine. It reads one-byte opcodes from a synchronous memory port, one byte per fetch, and runs a very small instruction set: a no-op, three literal pushes that take 1, 2 or 4 inline bytes from the instruction stream, and four sized stores that write 1, 2, 4 or 8 bytes to memory. The data stack is three registers deep. There is no return stack, no arithmetic and no branching, so a program is a straight run of literals and stores that ends on an opcode the core does not know.

Instruction fetch and data writes share one request port. The port carries an 8-lane byte enable and has one cycle of read latency. A store takes its address from the top of the stack and its data from the entry below it. The data is moved into the byte lanes chosen by the low address bits, with those bits first rounded down to the natural alignment of the access size. Any opcode outside the eight defined values raises a sticky halt flag and stops all memory traffic until reset.

Top module: `stk_core`

## Requirements
- R1: While reset is asserted, `halted` is 0. In the cycle after reset is released, the core issues a read (`mem_req`=1, `mem_we`=0) of the aligned word at address 0 with `mem_be`=8'h01.
- R2: The opcodes are 0x00 no-op, 0x01/0x02/0x03 literal of 1/2/4 bytes, and 0x10+k a store of 2^k bytes for k=0..3. A no-op changes nothing but the fetch address.
- R3: A literal takes the opcode's width of bytes that follow it, least significant byte first, zero-extends them to 64 bits and pushes the result. Those literal bytes are never decoded as opcodes.
- R4: A push moves top to second and second to third, and drops the old third entry.
- R5: A store uses the top entry as the byte address and the second entry as the data, then pops both. The old third entry becomes the top, and the two lower entries become zero.
- R6: A store of n bytes writes the word at address {top[63:3],3'b000}. Its lane offset is top[2:0] rounded down to a multiple of n, `mem_be` holds n consecutive ones starting at that offset, and the low n bytes of the data sit in those lanes.
- R7: During a write, every `mem_wdata` byte outside the enabled lanes is zero.
- R8: A no-op takes 2 cycles, a literal of n bytes takes 2+2n cycles, and a store takes 3 cycles, with its write request in the third.
- R9: An undefined opcode sets `halted` 2 cycles after its fetch request starts. `halted` then stays 1 and `mem_req` stays 0 until reset.
- R10: Each fetch is a read with exactly one byte enable set, at lane pc[2:0]. The byte is taken from `mem_rdata` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_req | output | 1 | Memory request valid this cycle |
| mem_we | output | 1 | 1 for a store write, 0 for an opcode or literal fetch |
| mem_addr | output | 64 | Word-aligned byte address of the access |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Write data, placed in the enabled lanes |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| halted | output | 1 | Sticky flag: an undefined opcode was fetched |

## Verification
Every instruction has a fixed cost: two cycles for each byte fetched and one more for the write of a store. While the bench builds a program, it adds up these costs and records the exact cycle (counted in clock edges since reset release) in which each write must appear and in which `halted` must rise. The monitor compares the write cycle, address, lanes and data against a queue kept in program order. It also checks that `halted` is seen first in exactly the predicted cycle, so an instruction that costs one cycle more or less moves every later result and is reported.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_LIT1  = 8'h01;
  localparam logic [7:0] OP_LIT2  = 8'h02;
  localparam logic [7:0] OP_LIT4  = 8'h03;
  localparam logic [7:0] OP_ST1   = 8'h10;
  localparam logic [7:0] OP_ST2   = 8'h11;
  localparam logic [7:0] OP_ST4   = 8'h12;
  localparam logic [7:0] OP_ST8   = 8'h13;

  typedef enum logic [1:0] {
    ST_REQ   = 2'd0,
    ST_RSP   = 2'd1,
    ST_STORE = 2'd2,
    ST_HALT  = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    K_NOP   = 2'd0,
    K_LIT   = 2'd1,
    K_STORE = 2'd2,
    K_BAD   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] size_log;
  } dec_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec.kind     = K_BAD;
    dec.size_log = 2'd0;
    case (opcode)
      OP_NOP:  dec.kind = K_NOP;
      OP_LIT1: begin dec.kind = K_LIT; dec.size_log = 2'd0; end
      OP_LIT2: begin dec.kind = K_LIT; dec.size_log = 2'd1; end
      OP_LIT4: begin dec.kind = K_LIT; dec.size_log = 2'd2; end
      OP_ST1, OP_ST2, OP_ST4, OP_ST8: begin
        dec.kind     = K_STORE;
        dec.size_log = opcode[1:0];
      end
      default: dec.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/stk_stack.sv
module stk_stack #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop2,
  input  logic [W-1:0] din,
  output logic [W-1:0] tos,
  output logic [W-1:0] nos
);

  logic [W-1:0] s0_q, s1_q, s2_q;
  logic [W-1:0] s0_d, s1_d, s2_d;
  logic         upd;

  assign upd = push | pop2;

  always_comb begin
    s0_d = s0_q;
    s1_d = s1_q;
    s2_d = s2_q;
    if (push) begin
      s0_d = din;
      s1_d = s0_q;
      s2_d = s1_q;
    end else if (pop2) begin
      s0_d = s2_q;
      s1_d = '0;
      s2_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
    end else if (upd) begin
      s0_q <= s0_d;
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign tos = s0_q;
  assign nos = s1_q;

endmodule

// File: rtl/stk_lanes.sv
module stk_lanes #(
  parameter int W = 64
) (
  input  logic [$clog2(W/8)-1:0] off_in,
  input  logic [1:0]             size_log,
  input  logic [W-1:0]           data,
  output logic [W/8-1:0]         be,
  output logic [W-1:0]           wdata
);

  localparam int NB    = W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [OFF_W:0]   n_bytes;
  logic [OFF_W-1:0] base;

  assign n_bytes = (OFF_W+1)'(1) << size_log;
  assign base    = off_in & ~OFF_W'(n_bytes - (OFF_W+1)'(1));

  always_comb begin
    be    = '0;
    wdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (i >= int'(base) && i < int'(base) + int'(n_bytes)) begin
        be[i]          = 1'b1;
        wdata[8*i +: 8] = data[8*(i - int'(base)) +: 8];
      end
    end
  end

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              halted
);

  localparam int NB     = XLEN / 8;
  localparam int OFF_W  = $clog2(NB);
  localparam int LIT_B  = 4;
  localparam int LIT_W  = 8 * LIT_B;
  localparam int IDX_W  = $clog2(LIT_B);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [LIT_W-1:0]  acc_q, acc_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        llog_q, llog_d;
  logic              inlit_q, inlit_d;
  logic [1:0]        sz_q, sz_d;
  logic              halt_q, halt_d;

  logic [7:0]        fbyte;
  dec_t              dec;
  logic              push, pop2;
  logic [XLEN-1:0]   push_val;
  logic [XLEN-1:0]   tos, nos;
  logic [NB-1:0]     st_be;
  logic [XLEN-1:0]   st_wdata;
  logic [IDX_W-1:0]  last_idx;

  assign fbyte    = mem_rdata[8*pc_q[OFF_W-1:0] +: 8];
  assign last_idx = IDX_W'((3'd1 << llog_q) - 3'd1);

  stk_decode u_dec (
    .opcode (fbyte),
    .dec    (dec)
  );

  stk_stack #(.W(XLEN)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop2  (pop2),
    .din   (push_val),
    .tos   (tos),
    .nos   (nos)
  );

  stk_lanes #(.W(XLEN)) u_lanes (
    .off_in   (tos[OFF_W-1:0]),
    .size_log (sz_q),
    .data     (nos),
    .be       (st_be),
    .wdata    (st_wdata)
  );

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    acc_d     = acc_q;
    idx_d     = idx_q;
    llog_d    = llog_q;
    inlit_d   = inlit_q;
    sz_d      = sz_q;
    halt_d    = halt_q;
    push      = 1'b0;
    pop2      = 1'b0;
    push_val  = '0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {pc_q[ADDR_W-1:OFF_W], OFF_W'(0)};
    mem_be    = '0;
    mem_wdata = '0;
    case (state_q)
      ST_REQ: begin
        mem_req = 1'b1;
        mem_be  = NB'(1) << pc_q[OFF_W-1:0];
        state_d = ST_RSP;
      end
      ST_RSP: begin
        pc_d    = pc_q + ADDR_W'(1);
        state_d = ST_REQ;
        if (inlit_q) begin
          acc_d[8*idx_q +: 8] = fbyte;
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == last_idx) begin
            push     = 1'b1;
            push_val = XLEN'(acc_d);
            inlit_d  = 1'b0;
          end
        end else begin
          case (dec.kind)
            K_NOP: ;
            K_LIT: begin
              inlit_d = 1'b1;
              idx_d   = '0;
              acc_d   = '0;
              llog_d  = dec.size_log;
            end
            K_STORE: begin
              sz_d    = dec.size_log;
              state_d = ST_STORE;
            end
            default: begin
              halt_d  = 1'b1;
              state_d = ST_HALT;
            end
          endcase
        end
      end
      ST_STORE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tos[ADDR_W-1:OFF_W], OFF_W'(0)};
        mem_be    = st_be;
        mem_wdata = st_wdata;
        pop2      = 1'b1;
        state_d   = ST_REQ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REQ;
      pc_q    <= RESET_PC;
      acc_q   <= '0;
      idx_q   <= '0;
      llog_q  <= '0;
      inlit_q <= 1'b0;
      sz_q    <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      acc_q   <= acc_d;
      idx_q   <= idx_d;
      llog_q  <= llog_d;
      inlit_q <= inlit_d;
      sz_q    <= sz_d;
      halt_q  <= halt_d;
    end
  end

  assign halted = halt_q;

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [XLEN/8-1:0] mem_be,
  input logic [XLEN-1:0]   mem_wdata,
  input logic              halted
);

  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] lane_mask;

  always_comb begin
    for (int i = 0; i < NB; i++) lane_mask[8*i +: 8] = {8{mem_be[i]}};
  end

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  // R6
  store_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                             $countones(mem_be) == 4 || $countones(mem_be) == 8));

  // R7
  store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & ~lane_mask) == '0));

  // R10
  fetch_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> ($countones(mem_be) == 1));

  // R8
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  // R8
  store_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (mem_req && !mem_we));

endmodule

bind stk_core stk_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .halted    (halted)
);

// File: tb/stk_core_bench.sv
module stk_core_bench;

  logic        clk;
  logic        rst_n;
  logic        mem_req;
  logic        mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;
  logic        halted;

  stk_core u_stk_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  prog [256];
  logic [63:0] m0, m1, m2;
  int          t, pcb, halt_t, cyc;
  int          checks = 0;
  int          failures = 0;
  logic        running = 1'b0;

  always @(posedge clk) begin
    if (mem_req && !mem_we)
      for (int i = 0; i < 8; i++)
        mem_rdata[8*i +: 8] <= prog[{mem_addr[7:3], 3'(i)}];
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && running && mem_req && mem_we) begin
      if (q.size() == 0) begin
        check(1'b0, "R5 unexpected write", mem_addr, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.cyc, {e.req, " R8 write cycle"}, 64'(cyc), 64'(e.cyc));
        check(mem_addr == e.addr, {e.req, " R6 address"}, mem_addr, e.addr);
        check(mem_be == e.be, {e.req, " R6 lanes"}, 64'(mem_be), 64'(e.be));
        check(mem_wdata == e.data, {e.req, " R7 data"}, mem_wdata, e.data);
      end
    end
  end

  task automatic begin_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'hFF;
    pcb = 0; t = 0; halt_t = -1;
    m0 = '0; m1 = '0; m2 = '0;
    q.delete();
  endtask

  task automatic op(input logic [7:0] b);
    prog[pcb] = b;
    pcb++;
    t += 2;
  endtask

  // R3 literal push model, R4 shift model
  task automatic lit(input int nb, input logic [31:0] v);
    logic [63:0] val;
    op(nb == 1 ? 8'h01 : (nb == 2 ? 8'h02 : 8'h03));
    for (int k = 0; k < nb; k++) op(v[8*k +: 8]);
    val = (nb == 4) ? {32'd0, v} : ({32'd0, v} & ((64'd1 << (8*nb)) - 64'd1));
    m2 = m1; m1 = m0; m0 = val;
  endtask

  // R5 / R6 store model
  task automatic st(input int lg, input string req);
    exp_t e;
    int n, off;
    logic [63:0] d;
    op(8'h10 + 8'(lg));
    n   = 1 << lg;
    off = int'(m0[2:0]) & ~(n - 1);
    d   = (n == 8) ? m1 : (m1 & ((64'd1 << (8*n)) - 64'd1));
    e.cyc  = t;
    e.addr = {m0[63:3], 3'b000};
    e.be   = 8'(((1 << n) - 1) << off);
    e.data = d << (8*off);
    e.req  = req;
    q.push_back(e);
    m0 = m2; m1 = '0; m2 = '0;
    t += 1;
  endtask

  task automatic bad(input logic [7:0] b);
    op(b);
    halt_t = t;
  endtask

  task automatic run_prog();
    logic seen;
    running = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(halted == 1'b0, "R1 halted low in reset", 64'(halted), 64'd0);
    rst_n = 1'b1;
    #1;
    check(mem_req && !mem_we && mem_addr == 64'd0 && mem_be == 8'h01,
          "R1 R10 first fetch", {mem_addr[55:0], mem_be}, 64'h01);
    running = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      @(negedge clk);
      if (halted) begin
        seen = 1'b1;
        check(cyc == halt_t, "R9 halt cycle", 64'(cyc), 64'(halt_t));
      end
    end
    if (!seen) check(1'b0, "R9 halt never seen (watchdog)", 64'd0, 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(halted && !mem_req, "R9 stays halted and quiet",
            {62'd0, halted, mem_req}, 64'd2);
    end
    check(q.size() == 0, "R5 all writes seen", 64'(q.size()), 64'd0);
    running = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    mem_rdata = '0;

    // R2 R8: no-ops then an undefined opcode
    begin_prog();
    op(8'h00); op(8'h00); op(8'h00);
    bad(8'h04);
    run_prog();

    // R3 R6: each literal width and each store width
    begin_prog();
    lit(1, 32'h5A);        lit(1, 32'h20);   st(0, "R6 byte");
    lit(2, 32'hBEEF);      lit(1, 32'h33);   st(1, "R6 half odd addr");
    lit(4, 32'hDEADBEEF);  lit(1, 32'h44);   st(2, "R6 word");
    lit(4, 32'h89ABCDEF);  lit(2, 32'h1238); st(3, "R3 R6 double");
    lit(1, 32'h80);        lit(1, 32'h08);   st(3, "R3 zero extend");
    bad(8'hFF);
    run_prog();

    // R4 R5: push past depth, pop with zero fill, third to top
    begin_prog();
    lit(1, 32'h11); lit(1, 32'h22); lit(1, 32'h33); lit(1, 32'h44);
    st(0, "R4 fourth push");
    lit(1, 32'h50); st(0, "R4 R5 survivor");
    st(0, "R5 zero fill");
    lit(1, 32'h77); lit(1, 32'h66); lit(1, 32'h58); st(0, "R5 addr data");
    lit(1, 32'h68); st(0, "R5 third to top");
    bad(8'h0F);
    run_prog();

    // R3 R6: literal bytes that look illegal, unaligned offsets
    begin_prog();
    lit(1, 32'hFF);        lit(1, 32'h3B); st(0, "R3 literal FF");
    lit(2, 32'hFFFF);      lit(1, 32'h7E); st(1, "R6 half lane 6");
    lit(4, 32'h01020304);  lit(1, 32'h47); st(2, "R6 word rounded");
    op(8'h00);
    lit(4, 32'h13131313);  lit(1, 32'h8F); st(3, "R2 R6 double rounded");
    bad(8'h14);
    run_prog();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule